// File: doc/BRIEF.md
# Two-Line Character Display Cursor Engine

This block takes a stream of 8-bit character codes and keeps a character buffer of two rows by sixteen columns, together with a cursor. It acts as a small line-oriented terminal in front of a character display. Ordinary codes are stored at the cursor position, and the cursor then steps forward. Carriage return, line feed and backspace only move the cursor. When the screen runs out of room, the whole buffer is blanked and writing starts again at the top-left cell. Nothing scrolls.

Characters arrive over a valid/ready handshake. Each stored character also appears for one cycle on a write port that gives the row, the column and the code, so that a downstream display driver can mirror the buffer. The start of each blanking pass produces a one-cycle clear pulse. The blanking pass walks every cell, one cell per clock, and the input is stalled while it runs. A combinational read port returns the code held in any cell, and the cursor position is brought out as well.

Top module: `char_grid_term`

## Requirements
- R1: After reset the cursor is at row 0, column 0, the wrap-pending flag is low, ready is high, and every cell reads blank (0x20).
- R2: An accepted code other than 0x08, 0x0A and 0x0D is stored at the cursor cell. In the next cycle the write port pulses with that row, column and code, and the cursor moves one column right.
- R3: A code stored in the last column of row 0 moves the cursor to row 1, column 0.
- R4: A code stored at row 1, column 15 sets the wrap-pending flag and leaves the cursor there. The next accepted code of any kind blanks the screen. If that code is an ordinary one, it is then stored at row 0, column 0 and the cursor moves to row 0, column 1.
- R5: A carriage return (0x0D) moves the cursor to column 0 of its current row. It stores nothing and leaves the buffer unchanged.
- R6: A line feed (0x0A) on row 0 moves the cursor to row 1 and keeps the column. It stores nothing.
- R7: A line feed on row 1 blanks the screen and leaves the cursor on row 0 in the same column.
- R8: A backspace (0x08) moves the cursor one column left and leaves that cell's code as it was. At row 1, column 0 it moves the cursor to row 0, column 15. At row 0, column 0 it has no effect.
- R9: A blanking pass raises the clear pulse for one cycle, in the cycle after the triggering code is accepted. Ready stays low for exactly 32 cycles. A code that is held valid during the pass is accepted only after the pass ends.
- R10: A control code that arrives while wrap-pending is set blanks the screen and then acts from row 0, column 0. A carriage return or backspace leaves the cursor at home. A line feed moves the cursor to row 1, column 0.
- R11: Codes outside the three control codes, including 0x00, 0x0C and 0xFF, are stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | A character code is offered |
| char_i | input | 8 | Offered character code |
| char_ready_o | output | 1 | Code accepted on this edge when valid is also high |
| wr_en_o | output | 1 | One-cycle pulse for a stored code |
| wr_row_o | output | 1 | Row of the stored code |
| wr_col_o | output | 4 | Column of the stored code |
| wr_char_o | output | 8 | Stored code |
| clr_o | output | 1 | One-cycle pulse at the start of a blanking pass |
| cur_row_o | output | 1 | Cursor row |
| cur_col_o | output | 4 | Cursor column |
| wrap_pend_o | output | 1 | Last cell filled; the next code blanks the screen |
| rd_row_i | input | 1 | Read port row |
| rd_col_i | input | 4 | Read port column |
| rd_char_o | output | 8 | Code held at the read cell (combinational) |

## Verification
The bench runs a short run of ordinary codes, which checks where each code is stored and how far the cursor steps. It then sends exactly sixteen and exactly thirty-two codes, which separates the wrap from row 0 to row 1 from the full-screen wrap. Each control code is tried from row 0, from row 1, from column 0 and from the wrap-pending state, so that a cursor move can be told apart from a blanking pass and from doing nothing. The length of each blanking pass is counted cycle by cycle, and a code is held valid during a pass to show that it waits. The unusual codes 0x00, 0x0C and 0xFF confirm that only the three control codes are decoded.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  localparam logic [7:0] CH_BS    = 8'h08;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_BLANK = 8'h20;

  typedef enum logic [1:0] {
    K_PLAIN,
    K_CR,
    K_LF,
    K_BS
  } code_kind_e;

  function automatic code_kind_e classify(input logic [7:0] code);
    case (code)
      CH_CR:   return K_CR;
      CH_LF:   return K_LF;
      CH_BS:   return K_BS;
      default: return K_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/cgt_step.sv
// Next cursor position and side effects for one code.
module cgt_step import cgt_pkg::*; #(
  parameter int ROWS = 2,
  parameter int COLS = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [7:0]       code_i,
  output logic [ROW_W-1:0] nrow_o,
  output logic [COL_W-1:0] ncol_o,
  output logic             store_o,
  output logic             full_o,
  output logic             wipe_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  code_kind_e kind;
  assign kind = classify(code_i);

  always_comb begin
    nrow_o  = row_i;
    ncol_o  = col_i;
    store_o = 1'b0;
    full_o  = 1'b0;
    wipe_o  = 1'b0;
    case (kind)
      K_CR: ncol_o = '0;
      K_LF: begin
        if (row_i == LAST_ROW) begin
          wipe_o = 1'b1;
          nrow_o = '0;
        end else begin
          nrow_o = row_i + ROW_W'(1);
        end
      end
      K_BS: begin
        if (col_i != '0) begin
          ncol_o = col_i - COL_W'(1);
        end else if (row_i != '0) begin
          nrow_o = row_i - ROW_W'(1);
          ncol_o = LAST_COL;
        end
      end
      default: begin
        store_o = 1'b1;
        if (col_i != LAST_COL) begin
          ncol_o = col_i + COL_W'(1);
        end else if (row_i != LAST_ROW) begin
          nrow_o = row_i + ROW_W'(1);
          ncol_o = '0;
        end else begin
          full_o = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/cgt_sweep.sv
// Blanking pass: one cell per cycle, busy for CELLS cycles.
module cgt_sweep #(
  parameter int CELLS = 32,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

  logic             act_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == LAST_IDX) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + IDX_W'(1);
      end
    end
  end

  assign busy_o = act_q;
  assign idx_o  = cnt_q;
  assign last_o = act_q && (cnt_q == LAST_IDX);
endmodule

// File: rtl/cgt_store.sv
// Cell storage; a character write takes priority over a blanking write.
module cgt_store import cgt_pkg::*; #(
  parameter int CELLS = 32,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             blank_en_i,
  input  logic [IDX_W-1:0] blank_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o
);
  logic [CELLS-1:0][7:0] cell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_q <= {CELLS{CH_BLANK}};
    end else begin
      for (int i = 0; i < CELLS; i++) begin
        if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
          cell_q[i] <= wr_data_i;
        end else if (blank_en_i && blank_idx_i == IDX_W'(i)) begin
          cell_q[i] <= CH_BLANK;
        end
      end
    end
  end

  generate
    if ((2 ** IDX_W) > CELLS) begin : g_rd_guard
      assign rd_data_o = (rd_idx_i < IDX_W'(CELLS)) ? cell_q[rd_idx_i] : CH_BLANK;
    end else begin : g_rd_direct
      assign rd_data_o = cell_q[rd_idx_i];
    end
  endgenerate
endmodule

// File: rtl/char_grid_term.sv
module char_grid_term import cgt_pkg::*; #(
  parameter int ROWS = 2,
  parameter int COLS = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_valid_i,
  input  logic [7:0]       char_i,
  output logic             char_ready_o,
  output logic             wr_en_o,
  output logic [ROW_W-1:0] wr_row_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic [7:0]       wr_char_o,
  output logic             clr_o,
  output logic [ROW_W-1:0] cur_row_o,
  output logic [COL_W-1:0] cur_col_o,
  output logic             wrap_pend_o,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [7:0]       rd_char_o
);
  localparam int CELLS = ROWS * COLS;
  localparam int IDX_W = $clog2(CELLS);

  logic [ROW_W-1:0] cur_row_q;
  logic [COL_W-1:0] cur_col_q;
  logic             full_q;
  logic             pend_q;
  logic [7:0]       pend_code_q;
  logic             wr_en_q;
  logic [ROW_W-1:0] wr_row_q;
  logic [COL_W-1:0] wr_col_q;
  logic [7:0]       wr_char_q;
  logic             clr_q;

  logic             sw_busy, sw_last;
  logic [IDX_W-1:0] sw_idx;
  logic             accept, replay, start_wipe;

  logic [ROW_W-1:0] st_row, st_nrow;
  logic [COL_W-1:0] st_col, st_ncol;
  logic [7:0]       st_code;
  logic             st_store, st_full, st_wipe;

  logic             do_store;
  logic [IDX_W-1:0] store_idx, rd_idx;

  assign char_ready_o = !sw_busy;
  assign accept       = char_valid_i && char_ready_o;
  // a code deferred by the wrap-pending state acts from home when the pass ends
  assign replay       = sw_last && pend_q;

  assign st_row  = replay ? '0 : cur_row_q;
  assign st_col  = replay ? '0 : cur_col_q;
  assign st_code = replay ? pend_code_q : char_i;

  cgt_step #(.ROWS(ROWS), .COLS(COLS)) u_step (
    .row_i   (st_row),
    .col_i   (st_col),
    .code_i  (st_code),
    .nrow_o  (st_nrow),
    .ncol_o  (st_ncol),
    .store_o (st_store),
    .full_o  (st_full),
    .wipe_o  (st_wipe)
  );

  assign start_wipe = accept && (full_q || st_wipe);
  assign do_store   = (accept && !full_q && !st_wipe && st_store) || (replay && st_store);
  assign store_idx  = IDX_W'(st_row) * IDX_W'(COLS) + IDX_W'(st_col);
  assign rd_idx     = IDX_W'(rd_row_i) * IDX_W'(COLS) + IDX_W'(rd_col_i);

  cgt_sweep #(.CELLS(CELLS)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_wipe),
    .busy_o  (sw_busy),
    .idx_o   (sw_idx),
    .last_o  (sw_last)
  );

  cgt_store #(.CELLS(CELLS)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (do_store),
    .wr_idx_i    (store_idx),
    .wr_data_i   (st_code),
    .blank_en_i  (sw_busy),
    .blank_idx_i (sw_idx),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_char_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_row_q   <= '0;
      cur_col_q   <= '0;
      full_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_code_q <= '0;
      wr_en_q     <= 1'b0;
      wr_row_q    <= '0;
      wr_col_q    <= '0;
      wr_char_q   <= '0;
      clr_q       <= 1'b0;
    end else begin
      wr_en_q <= do_store;
      clr_q   <= start_wipe;
      if (do_store) begin
        wr_row_q  <= st_row;
        wr_col_q  <= st_col;
        wr_char_q <= st_code;
      end
      if (accept) begin
        if (full_q) begin
          full_q      <= 1'b0;
          pend_q      <= 1'b1;
          pend_code_q <= char_i;
        end else begin
          cur_row_q <= st_nrow;
          cur_col_q <= st_ncol;
          full_q    <= st_full;
        end
      end else if (replay) begin
        pend_q    <= 1'b0;
        cur_row_q <= st_nrow;
        cur_col_q <= st_ncol;
        full_q    <= st_full;
      end
    end
  end

  assign wr_en_o     = wr_en_q;
  assign wr_row_o    = wr_row_q;
  assign wr_col_o    = wr_col_q;
  assign wr_char_o   = wr_char_q;
  assign clr_o       = clr_q;
  assign cur_row_o   = cur_row_q;
  assign cur_col_o   = cur_col_q;
  assign wrap_pend_o = full_q;
endmodule

// File: rtl/cgt_chk.sv
module cgt_chk import cgt_pkg::*; #(
  parameter int ROWS = 2,
  parameter int COLS = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CELLS = ROWS * COLS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_valid_i,
  input logic [7:0]       char_i,
  input logic             char_ready_o,
  input logic             wr_en_o,
  input logic [ROW_W-1:0] wr_row_o,
  input logic [COL_W-1:0] wr_col_o,
  input logic [7:0]       wr_char_o,
  input logic             clr_o,
  input logic [ROW_W-1:0] cur_row_o,
  input logic [COL_W-1:0] cur_col_o,
  input logic             wrap_pend_o
);
  logic acc, plain;
  logic [$clog2(CELLS)+1:0] low_cnt;

  assign acc   = char_valid_i && char_ready_o && !wrap_pend_o;
  assign plain = (char_i != CH_BS) && (char_i != CH_LF) && (char_i != CH_CR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt <= '0;
    else if (!char_ready_o) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  // R2
  print_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && plain |=> wr_en_o && wr_row_o == $past(cur_row_o)
                     && wr_col_o == $past(cur_col_o) && wr_char_o == $past(char_i));

  // R4
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_pend_o |-> cur_row_o == ROW_W'(ROWS - 1) && cur_col_o == COL_W'(COLS - 1));

  // R5
  cr_home_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && char_i == CH_CR |=> cur_col_o == '0 && cur_row_o == $past(cur_row_o) && !wr_en_o);

  // R6
  lf_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && char_i == CH_LF && cur_row_o == '0
      |=> cur_row_o == ROW_W'(1) && cur_col_o == $past(cur_col_o) && !wr_en_o);

  // R8
  bs_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && char_i == CH_BS && cur_row_o == '0 && cur_col_o == '0
      |=> cur_row_o == '0 && cur_col_o == '0 && !wr_en_o && !clr_o);

  // R9
  clr_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> !char_ready_o && !wr_en_o);

  // R9
  wipe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(char_ready_o) |-> low_cnt == ($clog2(CELLS)+2)'(CELLS));
endmodule

bind char_grid_term cgt_chk #(.ROWS(ROWS), .COLS(COLS)) u_cgt_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .char_valid_i (char_valid_i),
  .char_i       (char_i),
  .char_ready_o (char_ready_o),
  .wr_en_o      (wr_en_o),
  .wr_row_o     (wr_row_o),
  .wr_col_o     (wr_col_o),
  .wr_char_o    (wr_char_o),
  .clr_o        (clr_o),
  .cur_row_o    (cur_row_o),
  .cur_col_o    (cur_col_o),
  .wrap_pend_o  (wrap_pend_o)
);

// File: tb/tb_char_grid_term.sv
module tb_char_grid_term;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] code = 8'h00;
  logic       ready, wr_en, clr, wrap;
  logic       wr_row, cur_row, rd_row;
  logic [3:0] wr_col, cur_col, rd_col;
  logic [7:0] wr_char, rd_char;
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  char_grid_term dut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(valid), .char_i(code),
    .char_ready_o(ready), .wr_en_o(wr_en), .wr_row_o(wr_row), .wr_col_o(wr_col),
    .wr_char_o(wr_char), .clr_o(clr), .cur_row_o(cur_row), .cur_col_o(cur_col),
    .wrap_pend_o(wrap), .rd_row_i(rd_row), .rd_col_i(rd_col), .rd_char_o(rd_char)
  );

  initial begin
    rd_row = 1'b0;
    rd_col = 4'd0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // returns at the negedge after the accepting edge
  task automatic send(input logic [7:0] c);
    @(negedge clk);
    valid = 1'b1;
    code  = c;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ready) @(negedge clk);
  endtask

  task automatic peek(input int r, input int c, output logic [7:0] d);
    rd_row = r[0];
    rd_col = c[3:0];
    #1;
    d = rd_char;
  endtask

  task automatic cursor_is(input string req, input int r, input int c);
    chk(req, {cur_row, 3'b0, cur_col}, {r[0], 3'b0, c[3:0]});
  endtask

  task automatic fill(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) send(base + 8'(i));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    int bad;
    do_reset();
    cursor_is("R1 cursor", 0, 0);
    chk("R1 ready", ready, 1);
    chk("R1 wrap", wrap, 0);
    chk("R1 outputs idle", {wr_en, clr}, 0);
    bad = 0;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 16; c++) begin
        peek(r, c, d);
        if (d !== 8'h20) bad++;
      end
    chk("R1 blank cells", bad, 0);
  endtask

  task automatic t_print();
    logic [7:0] d;
    do_reset();
    send(8'h41);
    chk("R2 write pulse", {wr_en, wr_row, wr_col, wr_char}, {1'b1, 1'b0, 4'd0, 8'h41});
    cursor_is("R2 cursor step", 0, 1);
    send(8'h42);
    chk("R2 second write", {wr_en, wr_row, wr_col, wr_char}, {1'b1, 1'b0, 4'd1, 8'h42});
    @(negedge clk);
    chk("R2 pulse one cycle", wr_en, 0);
    peek(0, 1, d);
    chk("R2 stored", d, 8'h42);
  endtask

  task automatic t_row_wrap();
    logic [7:0] d;
    do_reset();
    fill(15, 8'h30);
    cursor_is("R3 before edge", 0, 15);
    send(8'h3F);
    chk("R3 last col write", {wr_row, wr_col}, {1'b0, 4'd15});
    cursor_is("R3 wrap to row1", 1, 0);
    send(8'h61);
    chk("R3 row1 write", {wr_row, wr_col, wr_char}, {1'b1, 4'd0, 8'h61});
    peek(0, 15, d);
    chk("R3 cell kept", d, 8'h3F);
  endtask

  task automatic t_full();
    logic [7:0] d;
    int n;
    do_reset();
    fill(32, 8'h40);
    chk("R4 wrap pending", wrap, 1);
    cursor_is("R4 cursor held", 1, 15);
    peek(1, 15, d);
    chk("R4 last cell", d, 8'h5F);
    send(8'h5A);
    chk("R9 clear pulse", {clr, ready, wr_en}, {1'b1, 1'b0, 1'b0});
    n = 0;
    while (!ready) begin
      n++;
      @(negedge clk);
    end
    chk("R9 stall length", n, 32);
    chk("R4 replay write", {wr_en, wr_row, wr_col, wr_char}, {1'b1, 1'b0, 4'd0, 8'h5A});
    cursor_is("R4 cursor after", 0, 1);
    chk("R4 wrap cleared", wrap, 0);
    peek(0, 0, d);
    chk("R4 home cell", d, 8'h5A);
    peek(1, 15, d);
    chk("R4 blanked last", d, 8'h20);
    peek(0, 5, d);
    chk("R4 blanked mid", d, 8'h20);
  endtask

  task automatic t_cr();
    logic [7:0] d;
    do_reset();
    fill(3, 8'h41);
    send(8'h0D);
    cursor_is("R5 cr row0", 0, 0);
    chk("R5 no write", {wr_en, clr}, 0);
    peek(0, 2, d);
    chk("R5 buffer kept", d, 8'h43);
    send(8'h78);
    chk("R5 overwrite home", {wr_row, wr_col, wr_char}, {1'b0, 4'd0, 8'h78});
    fill(17, 8'h50);
    cursor_is("R5 setup row1", 1, 2);
    send(8'h0D);
    cursor_is("R5 cr row1", 1, 0);
  endtask

  task automatic t_lf();
    logic [7:0] d;
    do_reset();
    fill(2, 8'h41);
    send(8'h0A);
    cursor_is("R6 lf down", 1, 2);
    chk("R6 no write", {wr_en, clr}, 0);
    send(8'h43);
    chk("R6 write row1", {wr_row, wr_col, wr_char}, {1'b1, 4'd2, 8'h43});
    send(8'h0A);
    chk("R7 clear pulse", clr, 1);
    cursor_is("R7 cursor top", 0, 3);
    // code held valid during the pass must wait for it to finish
    send(8'h51);
    chk("R9 held code stored after pass", {wr_row, wr_col, wr_char}, {1'b0, 4'd3, 8'h51});
    peek(0, 0, d);
    chk("R7 blanked", d, 8'h20);
    peek(1, 2, d);
    chk("R7 blanked row1", d, 8'h20);
  endtask

  task automatic t_bs();
    logic [7:0] d;
    do_reset();
    send(8'h08);
    cursor_is("R8 bs home", 0, 0);
    chk("R8 bs home quiet", {wr_en, clr}, 0);
    fill(2, 8'h41);
    send(8'h08);
    cursor_is("R8 bs step", 0, 1);
    peek(0, 1, d);
    chk("R8 cell untouched", d, 8'h42);
    do_reset();
    fill(16, 8'h30);
    send(8'h08);
    cursor_is("R8 bs row up", 0, 15);
    peek(0, 15, d);
    chk("R8 row up cell kept", d, 8'h3F);
  endtask

  task automatic t_full_ctrl();
    do_reset();
    fill(32, 8'h40);
    send(8'h0A);
    chk("R10 lf clear", clr, 1);
    wait_idle();
    cursor_is("R10 lf from home", 1, 0);
    chk("R10 lf no write", wr_en, 0);
    do_reset();
    fill(32, 8'h40);
    send(8'h0D);
    wait_idle();
    cursor_is("R10 cr home", 0, 0);
    do_reset();
    fill(32, 8'h40);
    send(8'h08);
    wait_idle();
    cursor_is("R10 bs home", 0, 0);
    chk("R10 wrap cleared", wrap, 0);
  endtask

  task automatic t_codes();
    logic [7:0] d;
    do_reset();
    send(8'hFF);
    send(8'h00);
    send(8'h0C);
    peek(0, 0, d);
    chk("R11 code ff", d, 8'hFF);
    peek(0, 1, d);
    chk("R11 code 00", d, 8'h00);
    peek(0, 2, d);
    chk("R11 code 0c", d, 8'h0C);
    cursor_is("R11 cursor", 0, 3);
  endtask

  initial begin
    t_reset();
    t_print();
    t_row_wrap();
    t_full();
    t_cr();
    t_lf();
    t_bs();
    t_full_ctrl();
    t_codes();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule